// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a two-way set-associative read cache. For every set it keeps one guess bit that names the way the next access to that set is likely to hit. A lookup reads the guessed way's tag and line. The output word select is already steered to that way, so the data read runs alongside the single tag compare. A correct guess answers in the cycle after the request is accepted. A wrong guess spends one more cycle comparing the other way's tag. If both ways miss, the line is fetched over a simple refill port and the answer comes back in the cycle the fetch completes.

Because the hit latency varies, every response carries a two-bit kind code. The code tells the requester which of the three paths produced the word. Requests are taken on a valid/ready handshake. Ready falls while the second-way compare or a refill is under way, so at most one request is past the lookup stage at any time. The cache is read-only: lines only enter it through refill.

Top module: `wpc_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0. Every line is invalid and every guess bit points to way 0, so the first access to any address is a full miss.
- R2: When the guessed way of the indexed set holds the request's tag, the response comes in the cycle after acceptance with kind 2'b01. Its data is word addr[OFF_W-1:0] of the cached line. req_ready stays 1 in that cycle, so hits can follow back to back.
- R3: rsp_kind is 2'b00 whenever rsp_valid is 0. When rsp_valid is 1 it is 2'b01 for a first-cycle hit, 2'b10 for a second-way hit and 2'b11 for a refilled miss.
- R4: When the guessed way misses and the other way holds the tag, the response comes two cycles after acceptance with kind 2'b10. No response is given in the cycle between.
- R5: When both ways miss, mem_req rises and stays high with a steady mem_addr equal to the line address addr[ADDR_W-1:OFF_W] until mem_done. In the mem_done cycle the response has kind 2'b11. Its data is word i of mem_line, taken from bits [i*DATA_W +: DATA_W], where i = addr[OFF_W-1:0].
- R6: After a second-way hit, the guess bit of that set names the way that hit, so the next access to the same line is a first-cycle hit.
- R7: A refill writes the least-recently-used way of the set and sets the guess bit to that way. Every hit or refill marks the other way as least recently used.
- R8: req_ready is 0 from the cycle after a lookup whose guess missed until the second-way hit or the refill response, and it is 0 whenever mem_req is 1.
- R9: The address splits into word offset addr[OFF_W-1:0], set index addr[OFF_W+IDX_W-1:OFF_W] and tag above that. Lines with the same tag in different sets are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address of the read |
| req_ready | output | 1 | Request is taken at this edge when valid |
| rsp_valid | output | 1 | Read response present this cycle |
| rsp_data | output | DATA_W | Read word |
| rsp_kind | output | 2 | 01 first-cycle hit, 10 second-way hit, 11 refilled miss, 00 idle |
| mem_req | output | 1 | Refill request, held until mem_done |
| mem_addr | output | ADDR_W-OFF_W | Line address being refilled |
| mem_line | input | DATA_W*WORDS | Refill line, word i in bits [i*DATA_W +: DATA_W] |
| mem_done | input | 1 | Refill line present, one cycle |

## Verification
The assertions assume that mem_done is asserted for exactly one cycle and only while mem_req is high. They also assume that mem_line is valid in that cycle. The bench memory model meets this by answering a fixed number of cycles after it sees mem_req and clearing mem_done on the following edge. The properties that tie a second-way or refill response to the cycles before it also rely on an in-order requester that waits on req_ready. The bench driver holds each request until it sees ready high and never has more than one request in the lookup stage.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   // Kind code returned with every response (values are part of the interface).
   typedef enum logic [1:0] {
      KIND_NONE   = 2'b00,
      KIND_FIRST  = 2'b01,
      KIND_SECOND = 2'b10,
      KIND_REFILL = 2'b11
   } wpc_kind_e;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_ALT  = 2'd1,
      ST_FILL = 2'd2
   } wpc_state_e;

   localparam int WPC_WAYS = 2;

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
   parameter int SETS  = 8,
   parameter int TAG_W = 7,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [IDX_W-1:0]                         rd_idx,
   output logic [wpc_pkg::WPC_WAYS-1:0]             rd_vld,
   output logic [wpc_pkg::WPC_WAYS-1:0][TAG_W-1:0]  rd_tag,
   input  logic                                     wr_en,
   input  logic                                     wr_way,
   input  logic [IDX_W-1:0]                         wr_idx,
   input  logic [TAG_W-1:0]                         wr_tag
);

   for (genvar w = 0; w < wpc_pkg::WPC_WAYS; w++) begin : g_way
      localparam logic WAY_ID = 1'(w);
      logic [SETS-1:0]  vld_q;
      logic [TAG_W-1:0] tag_q [SETS];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= '0;
         end else if (wr_en && (wr_way == WAY_ID)) begin
            vld_q[wr_idx] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && (wr_way == WAY_ID)) begin
            tag_q[wr_idx] <= wr_tag;
         end
      end

      assign rd_vld[w] = vld_q[rd_idx];
      assign rd_tag[w] = tag_q[rd_idx];
   end

endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
   parameter int SETS   = 8,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   localparam int IDX_W  = $clog2(SETS),
   localparam int OFF_W  = $clog2(WORDS),
   localparam int SEL_W  = (OFF_W > 0) ? OFF_W : 1,
   localparam int LINE_W = DATA_W * WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_way,
   input  logic [SEL_W-1:0]  rd_word,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic              wr_way,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line
);

   logic [wpc_pkg::WPC_WAYS-1:0][LINE_W-1:0] rows;
   logic [LINE_W-1:0]                        row_sel;

   for (genvar w = 0; w < wpc_pkg::WPC_WAYS; w++) begin : g_way
      localparam logic WAY_ID = 1'(w);
      logic [LINE_W-1:0] line_q [SETS];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_way == WAY_ID)) begin
            line_q[wr_idx] <= wr_line;
         end
      end

      assign rows[w] = line_q[rd_idx];
   end

   // Way steering happens ahead of any tag result.
   assign row_sel = rows[rd_way];

   if (WORDS == 1) begin : g_single_word
      logic unused_sel;
      assign unused_sel = ^rd_word;
      assign rd_data    = row_sel;
   end else begin : g_multi_word
      assign rd_data = DATA_W'(row_sel >> (LINE_W'(rd_word) * LINE_W'(DATA_W)));
   end

endmodule

// File: rtl/wpc_guess_lru.sv
module wpc_guess_lru #(
   parameter int SETS = 8,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic             guess_q,
   output logic             lru_q,
   input  logic             guess_we,
   input  logic             guess_d,
   input  logic             lru_we,
   input  logic             lru_d
);

   logic [SETS-1:0] guess_bits;
   logic [SETS-1:0] lru_bits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         guess_bits <= '0;
         lru_bits   <= '0;
      end else begin
         if (guess_we) guess_bits[idx] <= guess_d;
         if (lru_we)   lru_bits[idx]   <= lru_d;
      end
   end

   assign guess_q = guess_bits[idx];
   assign lru_q   = lru_bits[idx];

endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
   import wpc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int SETS   = 8,
   localparam int OFF_W   = $clog2(WORDS),
   localparam int IDX_W   = $clog2(SETS),
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
   localparam int LADDR_W = ADDR_W - OFF_W,
   localparam int LINE_W  = DATA_W * WORDS,
   localparam int SEL_W   = (OFF_W > 0) ? OFF_W : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               req_ready,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data,
   output logic [1:0]         rsp_kind,
   output logic               mem_req,
   output logic [LADDR_W-1:0] mem_addr,
   input  logic [LINE_W-1:0]  mem_line,
   input  logic               mem_done
);

   // Elaboration-time parameter checks
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("wpc_cache: SETS must be a power of two and at least 2");
   end
   if (WORDS < 1 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("wpc_cache: WORDS must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wpc_cache: ADDR_W too small for SETS and WORDS");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("wpc_cache: DATA_W must be positive");
   end

   // Lookup stage
   wpc_state_e        state_q, state_d;
   logic              s_vld;
   logic [ADDR_W-1:0] s_addr;
   logic [IDX_W-1:0]  s_idx;
   logic [TAG_W-1:0]  s_tag;
   logic [SEL_W-1:0]  s_word;
   wpc_kind_e         kind;

   assign s_word   = SEL_W'(s_addr & ADDR_W'(WORDS - 1));
   assign s_idx    = IDX_W'(s_addr >> OFF_W);
   assign s_tag    = TAG_W'(s_addr >> (OFF_W + IDX_W));
   assign mem_addr = LADDR_W'(s_addr >> OFF_W);

   // Stores
   logic                                     guess_way, victim_way;
   logic                                     look_way, hit_way, look_hit;
   logic [WPC_WAYS-1:0]                      way_vld;
   logic [WPC_WAYS-1:0][TAG_W-1:0]           way_tag;
   logic [DATA_W-1:0]                        store_word;
   logic                                     fill_now;
   logic                                     guess_we, guess_d;

   // Second cycle checks the way that was not guessed.
   assign look_way = (state_q == ST_ALT) ? ~guess_way : guess_way;
   assign look_hit = way_vld[look_way] && (way_tag[look_way] == s_tag);
   assign fill_now = (state_q == ST_FILL) && mem_done;
   assign hit_way  = fill_now ? victim_way : look_way;

   assign guess_we = ((state_q == ST_ALT) && look_hit) || fill_now;
   assign guess_d  = fill_now ? victim_way : look_way;

   wpc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (s_idx),
      .rd_vld (way_vld),
      .rd_tag (way_tag),
      .wr_en  (fill_now),
      .wr_way (victim_way),
      .wr_idx (s_idx),
      .wr_tag (s_tag)
   );

   wpc_data_store #(.SETS(SETS), .DATA_W(DATA_W), .WORDS(WORDS)) u_data (
      .clk     (clk),
      .rd_idx  (s_idx),
      .rd_way  (look_way),
      .rd_word (s_word),
      .rd_data (store_word),
      .wr_en   (fill_now),
      .wr_way  (victim_way),
      .wr_idx  (s_idx),
      .wr_line (mem_line)
   );

   wpc_guess_lru #(.SETS(SETS)) u_guess (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (s_idx),
      .guess_q  (guess_way),
      .lru_q    (victim_way),
      .guess_we (guess_we),
      .guess_d  (guess_d),
      .lru_we   (rsp_valid),
      .lru_d    (~hit_way)
   );

   // Control
   always_comb begin
      state_d   = state_q;
      rsp_valid = 1'b0;
      kind      = KIND_NONE;
      unique case (state_q)
         ST_RUN: begin
            if (s_vld) begin
               if (look_hit) begin
                  rsp_valid = 1'b1;
                  kind      = KIND_FIRST;
               end else begin
                  state_d = ST_ALT;
               end
            end
         end
         ST_ALT: begin
            if (look_hit) begin
               rsp_valid = 1'b1;
               kind      = KIND_SECOND;
               state_d   = ST_RUN;
            end else begin
               state_d = ST_FILL;
            end
         end
         ST_FILL: begin
            if (mem_done) begin
               rsp_valid = 1'b1;
               kind      = KIND_REFILL;
               state_d   = ST_RUN;
            end
         end
         default: state_d = ST_RUN;
      endcase
   end

   assign rsp_kind  = kind;
   assign req_ready = (state_q == ST_RUN) && (!s_vld || look_hit);
   assign mem_req   = (state_q == ST_FILL);
   assign rsp_data  = (state_q == ST_FILL)
                    ? DATA_W'(mem_line >> (LINE_W'(s_word) * LINE_W'(DATA_W)))
                    : store_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         s_vld   <= 1'b0;
         s_addr  <= '0;
      end else begin
         state_q <= state_d;
         if (req_valid && req_ready) begin
            s_vld  <= 1'b1;
            s_addr <= req_addr;
         end else if (rsp_valid) begin
            s_vld <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wpc_cache_chk.sv
module wpc_cache_chk #(
   parameter int LADDR_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               rsp_valid,
   input logic [1:0]         rsp_kind,
   input logic               mem_req,
   input logic               mem_done,
   input logic [LADDR_W-1:0] mem_addr
);

   // R3: idle code whenever no response is presented
   assert_idle_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_kind == 2'b00));

   // R4: a second-way answer follows a silent, stalled cycle
   assert_second_after_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'b10) |-> ($past(!rsp_valid) && $past(!req_ready)));

   // R5: a refill answer only comes with the completion of a pending fetch
   assert_refill_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'b11) |-> (mem_req && mem_done));

   // R5: fetch request held with a steady line address until completion
   assert_fetch_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr)));

   // R5: fetch request drops only after completion
   assert_fetch_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_req) |-> $past(mem_done));

   // R8: no new request taken while a fetch is pending
   assert_stall_in_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

endmodule

bind wpc_cache wpc_cache_chk #(.LADDR_W(LADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_kind  (rsp_kind),
   .mem_req   (mem_req),
   .mem_done  (mem_done),
   .mem_addr  (mem_addr)
);

// File: tb/sim_wpc_cache.sv
module sim_wpc_cache;

   localparam int ADDR_W  = 12;
   localparam int DATA_W  = 32;
   localparam int WORDS   = 4;
   localparam int SETS    = 8;
   localparam int OFF_W   = $clog2(WORDS);
   localparam int IDX_W   = $clog2(SETS);
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
   localparam int LADDR_W = ADDR_W - OFF_W;
   localparam int LINE_W  = DATA_W * WORDS;
   localparam int MEM_LAT = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic               req_ready;
   logic               rsp_valid;
   logic [DATA_W-1:0]  rsp_data;
   logic [1:0]         rsp_kind;
   logic               mem_req;
   logic [LADDR_W-1:0] mem_addr;
   logic [LINE_W-1:0]  mem_line = '0;
   logic               mem_done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   wpc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .SETS(SETS)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_kind(rsp_kind), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_line(mem_line), .mem_done(mem_done)
   );

   typedef struct {
      logic [ADDR_W-1:0] addr;
      logic [1:0]        kind;
      logic [DATA_W-1:0] data;
      int                acc;
      string             lbl;
   } item_t;

   item_t sbq[$];
   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Independent model of tags, guesses and LRU, built from the requirements
   bit               mvld  [2][SETS];
   logic [TAG_W-1:0] mtag  [2][SETS];
   bit               mguess[SETS];
   bit               mlru  [SETS];

   function automatic logic [DATA_W-1:0] mem_word(input logic [LADDR_W-1:0] la, input int w);
      return DATA_W'((32'(la) * 32'h9E37_79B1) ^ (32'(w) * 32'h0101_0101) ^ 32'h5A5A_0000);
   endfunction

   function automatic logic [ADDR_W-1:0] mk_addr(input int t, input int s, input int w);
      return ADDR_W'((t << (OFF_W + IDX_W)) | (s << OFF_W) | w);
   endfunction

   function automatic logic [1:0] model_access(input logic [ADDR_W-1:0] a);
      int idx;
      logic [TAG_W-1:0] tg;
      bit p, v;
      idx = int'(a >> OFF_W) % SETS;
      tg  = TAG_W'(a >> (OFF_W + IDX_W));
      p   = mguess[idx];
      if (mvld[p][idx] && mtag[p][idx] == tg) begin
         mlru[idx] = !p;
         return 2'b01;
      end
      if (mvld[!p][idx] && mtag[!p][idx] == tg) begin
         mguess[idx] = !p;
         mlru[idx]   = p;
         return 2'b10;
      end
      v = mlru[idx];
      mvld[v][idx] = 1'b1;
      mtag[v][idx] = tg;
      mguess[idx]  = v;
      mlru[idx]    = !v;
      return 2'b11;
   endfunction

   // Driver: pushes the expected item, then presents the request
   task automatic access(input logic [ADDR_W-1:0] a, input string lbl);
      item_t it;
      it.addr = a;
      it.kind = model_access(a);
      it.data = mem_word(LADDR_W'(a >> OFF_W), int'(a) % WORDS);
      it.lbl  = lbl;
      req_valid = 1'b1;
      req_addr  = a;
      while (!req_ready) @(negedge clk);
      it.acc = cyc;
      sbq.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      if (it.kind != 2'b01)
         check(req_ready == 1'b0, "R8", "ready after guessed-way miss", 64'(req_ready), 64'd0);
   endtask

   // Monitor: compares responses against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (rsp_valid) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R3", "response with empty scoreboard", 64'(rsp_kind), 64'd0);
            end else begin
               item_t it;
               int lat;
               it  = sbq.pop_front();
               lat = cyc - it.acc;
               check(rsp_kind == it.kind, "R3", {it.lbl, " kind"}, 64'(rsp_kind), 64'(it.kind));
               check(rsp_data == it.data, it.kind == 2'b11 ? "R5" : "R2",
                     {it.lbl, " data"}, 64'(rsp_data), 64'(it.data));
               if (it.kind == 2'b01)
                  check(lat == 1, "R2", {it.lbl, " first-cycle latency"}, 64'(lat), 64'd1);
               else if (it.kind == 2'b10)
                  check(lat == 2, "R4", {it.lbl, " second-way latency"}, 64'(lat), 64'd2);
               else
                  check(lat >= 3, "R5", {it.lbl, " refill latency"}, 64'(lat), 64'd3);
            end
         end else if (rsp_kind != 2'b00) begin
            check(1'b0, "R3", "idle kind code", 64'(rsp_kind), 64'd0);
         end
      end
   end

   // Memory model: answers MEM_LAT cycles after seeing a fetch request
   int mcnt = 0;
   always @(posedge clk) begin
      #1;
      if (mem_done) begin
         mem_done = 1'b0;
      end else if (mem_req) begin
         if (mcnt == 0 && sbq.size() != 0)
            check(mem_addr == LADDR_W'(sbq[0].addr >> OFF_W), "R5", "fetch line address",
                  64'(mem_addr), 64'(sbq[0].addr >> OFF_W));
         if (mcnt == MEM_LAT) begin
            for (int w = 0; w < WORDS; w++)
               mem_line[w*DATA_W +: DATA_W] = mem_word(mem_addr, w);
            mem_done = 1'b1;
            mcnt = 0;
         end else begin
            mcnt++;
         end
      end
   end

   task automatic summary();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

   localparam int TA = 5, TB = 9, TC = 12, TD = 3;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      check(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
      check(rsp_valid == 1'b0, "R1", "no response after reset", 64'(rsp_valid), 64'd0);
      check(mem_req == 1'b0, "R1", "no fetch after reset", 64'(mem_req), 64'd0);

      // Directed sequence on set 2
      access(mk_addr(TA, 2, 0), "R1 first access misses");
      access(mk_addr(TA, 2, 3), "R2 guessed hit");
      access(mk_addr(TA, 2, 1), "R2 back-to-back hit");
      access(mk_addr(TA, 2, 2), "R2 back-to-back hit");
      access(mk_addr(TB, 2, 1), "R7 fill other way");
      access(mk_addr(TA, 2, 0), "R4 second-way hit");
      access(mk_addr(TA, 2, 3), "R6 guess follows second-way hit");
      access(mk_addr(TB, 2, 2), "R4 second-way hit");
      access(mk_addr(TC, 2, 0), "R7 evict LRU way");
      access(mk_addr(TA, 2, 1), "R7 evicted line misses");
      access(mk_addr(TA, 2, 2), "R7 guess set to filled way");
      access(mk_addr(TC, 2, 3), "R4 survivor in other way");
      // R9: same tag, other set is independent; offset picks word
      access(mk_addr(TA, 5, 2), "R9 other set misses");
      access(mk_addr(TA, 5, 0), "R9 word offset");
      access(mk_addr(TA, 2, 3), "R9 original set untouched");

      // Mixed stream
      for (int i = 0; i < 400; i++) begin
         int t;
         case ($urandom % 4)
            0: t = TA;
            1: t = TB;
            2: t = TC;
            default: t = TD;
         endcase
         access(mk_addr(t, int'($urandom % SETS), int'($urandom % WORDS)), "mix");
      end

      for (int i = 0; i < 50 && sbq.size() != 0; i++) @(negedge clk);
      check(sbq.size() == 0, "R3", "all responses returned", 64'(sbq.size()), 64'd0);
      summary();
      $finish;
   end

endmodule